// File: doc/BRIEF.md
# Segmented Instruction Cache Controller

This block is an automatic instruction cache placed between a processor's fetch port and a slower program memory. It stores 128 words of 32 bits as four segments of 32 words. Each segment carries one tag holding address bits 31..5, and every stored word has its own present flag. Tags therefore cover a whole segment, but a miss brings in only the single requested word, through a request/acknowledge port to the external memory.

A fetch compares bits 31..5 against all four tags at once. If a tag matches and the word's present flag is set, the data is returned in the same cycle. If a tag matches but the flag is clear, the word is fetched and filled. If no tag matches, the least recently used segment is retargeted to the new tag, its flags are cleared, and the word is then filled. A one-cycle flush input clears every present flag and restores a fixed recency order. Tags are kept through a flush.

The controller has three states. `ST_IDLE` serves hits. On a word miss it moves to `ST_FILL`, and on a tag miss to `ST_EVICT`. `ST_EVICT` loads the victim segment's tag, clears its flags, and always moves to `ST_FILL` after one cycle. `ST_FILL` holds the memory request until `mem_ack`, returns the word in that same cycle, and goes back to `ST_IDLE`. A flush forces `ST_IDLE` from any state and abandons a pending fill. The processor keeps `fetch_req` and `fetch_addr` steady until `fetch_ready`. Addresses are word addresses.

Top module: `icache_ctrl`

## Requirements
- R1: A word is located by address bits 31..5, which select the segment by tag match, and bits 4..0, which give its offset within that segment. A fetch always returns the value the external memory supplied for that exact address.
- R2: When a tag matches and the word's present flag is 1, `fetch_ready` is 1 and `fetch_data` is valid in the request cycle itself, and `mem_req` stays 0.
- R3: When a tag matches but the present flag is 0, `mem_req` rises in the cycle after the request with `mem_addr` equal to `fetch_addr`. The word is returned with `fetch_ready` in the cycle where `mem_ack` is 1, and later fetches of that word hit.
- R4: When no tag matches, there is one cycle with `mem_req` 0 in which the victim segment takes the new tag and all 32 of its present flags are cleared. `mem_req` follows in the next cycle. A given tag is held by at most one segment.
- R5: Every hit and every completed fill makes the accessed segment the most recently used, and the other segments keep their relative order. A tag miss replaces the least recently used segment.
- R6: A one-cycle `flush` clears all 128 present flags and keeps the tags, so the next fetch to a resident tag is a word miss.
- R7: `flush` sets the recency order so that segment 0 is most recent and segment 3 is least recent. The next tag miss therefore replaces segment 3.
- R8: While a fill waits for `mem_ack`, `mem_req` stays 1 with a stable `mem_addr`, and `fetch_ready` stays 0.
- R9: After reset no segment holds a tag, so the first fetch of any tag is a tag miss, and `fetch_ready` and `mem_req` are 0 while no fetch is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Clear all present flags and reset recency order |
| fetch_req | input | 1 | Processor fetch request, held until fetch_ready |
| fetch_addr | input | 32 | Word address of the fetch |
| fetch_ready | output | 1 | Fetch data valid this cycle |
| fetch_data | output | 32 | Returned instruction word |
| mem_req | output | 1 | Request to external memory |
| mem_addr | output | 32 | Word address for external memory |
| mem_ack | input | 1 | External memory returns data this cycle |
| mem_data | input | 32 | Data from external memory |

## Verification
The bench measures the gap between each fetch and `mem_req` to tell a hit, a word miss and a tag miss apart. This exposes which segment was replaced: a wrong LRU update or victim choice turns an expected one-cycle miss into a two-cycle one, or the reverse. Directed sequences reuse an evicted segment at an offset the old tag had filled, which catches flags left set after retargeting. They also issue a tag miss right after a flush, which catches a recency order that was not reset. Offsets 0 and 31 and random acknowledge delays look for indexing slips and for a request that drops or changes address while waiting.

// File: rtl/icache_pkg.sv
package icache_pkg;

    // Controller sequencing: serve hits, retarget a segment, fill one word.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVICT = 2'd1,
        ST_FILL  = 2'd2
    } fill_state_t;

endpackage

// File: rtl/icache_lru.sv
module icache_lru #(
    parameter int NSEG  = 4,
    parameter int SEG_W = $clog2(NSEG)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             touch_en,
    input  logic [SEG_W-1:0] touch_seg,
    output logic [SEG_W-1:0] victim
);

    // order[0] is most recent, order[NSEG-1] least recent
    logic [SEG_W-1:0] order     [NSEG];
    logic [SEG_W-1:0] order_nxt [NSEG];
    logic [SEG_W-1:0] hit_pos;
    logic [NSEG-1:0]  occupied;

    always_comb begin
        hit_pos = '0;
        for (int i = 0; i < NSEG; i++) begin
            if (order[i] == touch_seg) hit_pos = SEG_W'(i);
        end
        order_nxt[0] = touch_seg;
        for (int i = 1; i < NSEG; i++) begin
            if (i <= int'(hit_pos)) order_nxt[i] = order[i-1];
            else                    order_nxt[i] = order[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NSEG; i++) order[i] <= SEG_W'(i);
        end else if (flush) begin
            for (int i = 0; i < NSEG; i++) order[i] <= SEG_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < NSEG; i++) order[i] <= order_nxt[i];
        end
    end

    assign victim = order[NSEG-1];

    always_comb begin
        occupied = '0;
        for (int i = 0; i < NSEG; i++) occupied[order[i]] = 1'b1;
    end

    // R5: the stack always names every segment exactly once
    assert_lru_perm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        occupied == {NSEG{1'b1}});

    // R5: a touched segment becomes most recent
    assert_lru_touch_mru_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (touch_en && !flush) |=> (order[0] == $past(touch_seg)));

    // R7: flush restores ascending order, least recent is the last segment
    assert_lru_flush_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (order[0] == '0 && victim == SEG_W'(NSEG-1)));

endmodule

// File: rtl/icache_tags.sv
module icache_tags #(
    parameter int NSEG  = 4,
    parameter int WPS   = 32,
    parameter int TAG_W = 27,
    parameter int SEG_W = $clog2(NSEG),
    parameter int OFF_W = $clog2(WPS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [TAG_W-1:0] lookup_tag,
    input  logic [OFF_W-1:0] lookup_off,
    input  logic             load_en,
    input  logic [SEG_W-1:0] load_seg,
    input  logic             set_en,
    input  logic [SEG_W-1:0] set_seg,
    input  logic [OFF_W-1:0] set_off,
    output logic             tag_hit,
    output logic [SEG_W-1:0] hit_seg,
    output logic             word_present
);

    logic [TAG_W-1:0]           tag_q [NSEG];
    logic [NSEG-1:0]            seg_valid;
    logic [NSEG-1:0][WPS-1:0]   present;
    logic [NSEG-1:0]            match;

    // parallel comparators, one per segment
    for (genvar g = 0; g < NSEG; g++) begin : g_cmp
        assign match[g] = seg_valid[g] && (tag_q[g] == lookup_tag);
    end

    always_comb begin
        hit_seg = '0;
        for (int i = NSEG - 1; i >= 0; i--) begin
            if (match[i]) hit_seg = SEG_W'(i);
        end
    end

    assign tag_hit      = |match;
    assign word_present = present[hit_seg][lookup_off];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seg_valid <= '0;
            present   <= '0;
            for (int i = 0; i < NSEG; i++) tag_q[i] <= '0;
        end else if (flush) begin
            present <= '0;
        end else begin
            if (load_en) begin
                tag_q[load_seg]     <= lookup_tag;
                seg_valid[load_seg] <= 1'b1;
                present[load_seg]   <= '0;
            end
            if (set_en) present[set_seg][set_off] <= 1'b1;
        end
    end

    // R4: a tag lives in at most one segment
    for (genvar a = 0; a < NSEG; a++) begin : g_uniq_a
        for (genvar b = a + 1; b < NSEG; b++) begin : g_uniq_b
            assert_tag_unique_R4: assert property (@(posedge clk) disable iff (!rst_n)
                !(seg_valid[a] && seg_valid[b] && tag_q[a] == tag_q[b]));
        end
    end

    // R4: a retargeted segment starts with every word absent
    assert_evict_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !flush) |=> (present[$past(load_seg)] == '0));

    // R6: flush empties every flag
    assert_flush_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (present == '0));

endmodule

// File: rtl/icache_store.sv
module icache_store #(
    parameter int DEPTH  = 128,
    parameter int DATA_W = 32,
    parameter int IDX_W  = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] words [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) words[wr_idx] <= wr_data;
    end

    assign rd_data = words[rd_idx];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
    import icache_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int NSEG   = 4,
    parameter int WPS    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              fetch_req,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              fetch_ready,
    output logic [DATA_W-1:0] fetch_data,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_ack,
    input  logic [DATA_W-1:0] mem_data
);

    localparam int OFF_W = $clog2(WPS);
    localparam int TAG_W = ADDR_W - OFF_W;
    localparam int SEG_W = $clog2(NSEG);
    localparam int IDX_W = SEG_W + OFF_W;

    fill_state_t       state, state_nxt;
    logic [SEG_W-1:0]  fill_seg, fill_seg_nxt;

    logic [TAG_W-1:0]  req_tag;
    logic [OFF_W-1:0]  req_off;
    logic              tag_hit, word_present;
    logic [SEG_W-1:0]  hit_seg, victim;
    logic              load_en, set_en, touch_en, idle_hit;
    logic [SEG_W-1:0]  touch_seg;
    logic [DATA_W-1:0] rd_data;

    assign req_tag = fetch_addr[ADDR_W-1:OFF_W];
    assign req_off = fetch_addr[OFF_W-1:0];

    icache_tags #(
        .NSEG(NSEG), .WPS(WPS), .TAG_W(TAG_W), .SEG_W(SEG_W), .OFF_W(OFF_W)
    ) u_tags (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lookup_tag(req_tag), .lookup_off(req_off),
        .load_en(load_en), .load_seg(fill_seg),
        .set_en(set_en), .set_seg(fill_seg), .set_off(req_off),
        .tag_hit(tag_hit), .hit_seg(hit_seg), .word_present(word_present)
    );

    icache_lru #(.NSEG(NSEG), .SEG_W(SEG_W)) u_lru (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .touch_en(touch_en), .touch_seg(touch_seg), .victim(victim)
    );

    icache_store #(.DEPTH(NSEG * WPS), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(set_en), .wr_idx({fill_seg, req_off}), .wr_data(mem_data),
        .rd_idx({hit_seg, req_off}), .rd_data(rd_data)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            fill_seg <= '0;
        end else begin
            state    <= state_nxt;
            fill_seg <= fill_seg_nxt;
        end
    end

    // transitions
    always_comb begin
        state_nxt    = state;
        fill_seg_nxt = fill_seg;
        unique case (state)
            ST_IDLE: begin
                if (fetch_req && !(tag_hit && word_present)) begin
                    if (tag_hit) begin
                        state_nxt    = ST_FILL;
                        fill_seg_nxt = hit_seg;
                    end else begin
                        state_nxt    = ST_EVICT;
                        fill_seg_nxt = victim;
                    end
                end
            end
            ST_EVICT: state_nxt = ST_FILL;
            ST_FILL:  if (mem_ack) state_nxt = ST_IDLE;
            default:  state_nxt = ST_IDLE;
        endcase
        if (flush) state_nxt = ST_IDLE;
    end

    // outputs and datapath strobes
    always_comb begin
        load_en     = 1'b0;
        set_en      = 1'b0;
        idle_hit    = 1'b0;
        mem_req     = 1'b0;
        fetch_data  = mem_data;
        unique case (state)
            ST_IDLE: begin
                idle_hit   = fetch_req && tag_hit && word_present && !flush;
                fetch_data = rd_data;
            end
            ST_EVICT: load_en = !flush;
            ST_FILL: begin
                mem_req = !flush;
                set_en  = mem_ack && !flush;
            end
            default: ;
        endcase
        fetch_ready = idle_hit || set_en;
        touch_en    = idle_hit || set_en;
        touch_seg   = idle_hit ? hit_seg : fill_seg;
    end

    assign mem_addr = fetch_addr;

    // R2: a hit never involves external memory
    assert_hit_no_mem_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && fetch_ready) |-> !mem_req);

    // R2: data is only handed out for a pending request
    assert_ready_has_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_ready |-> fetch_req);

    // R8: a waiting request stays up with a stable address
    assert_req_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack && !flush) |=> ((mem_req || flush) && $stable(mem_addr)));

    // R4: a retarget cycle is always followed by a fill
    assert_evict_to_fill_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT && !flush) |=> (state == ST_FILL));

endmodule

// File: tb/icache_ctrl_tb.sv
`timescale 1ns/100ps
module icache_ctrl_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        flush = 1'b0;
    logic        fetch_req = 1'b0;
    logic [31:0] fetch_addr = '0;
    logic        fetch_ready;
    logic [31:0] fetch_data;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [31:0] mem_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    icache_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr),
        .fetch_ready(fetch_ready), .fetch_data(fetch_data),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_data(mem_data)
    );

    // reference model built from the requirements
    bit          m_valid [4];
    logic [26:0] m_tag   [4];
    bit [31:0]   m_pres  [4];
    int          m_order [4];

    function automatic logic [31:0] ext_word(input logic [31:0] a);
        return (a * 32'h9E3779B1) ^ 32'h5A5A0F0F;
    endfunction

    function automatic int find_seg(input logic [26:0] t);
        for (int i = 0; i < 4; i++) if (m_valid[i] && m_tag[i] == t) return i;
        return -1;
    endfunction

    task automatic touch(input int s);
        int p = 0;
        for (int i = 0; i < 4; i++) if (m_order[i] == s) p = i;
        for (int i = p; i > 0; i--) m_order[i] = m_order[i-1];
        m_order[0] = s;
    endtask

    task automatic chk(input bit ok, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic do_fetch(input logic [31:0] a, input string lbl);
        int s;
        int o = int'(a[4:0]);
        int d;
        @(negedge clk);
        fetch_req  = 1'b1;
        fetch_addr = a;
        #0.5;
        s = find_seg(a[31:5]);
        if (s >= 0 && m_pres[s][o]) begin
            chk(fetch_ready === 1'b1, {"R2 hit ready ", lbl}, 32'(fetch_ready), 1);
            chk(fetch_data === ext_word(a), {"R1 R2 hit data ", lbl}, fetch_data, ext_word(a));
            chk(mem_req === 1'b0, {"R2 hit no memory ", lbl}, 32'(mem_req), 0);
            touch(s);
            @(negedge clk);
        end else begin
            chk(fetch_ready === 1'b0, {"R3 R4 miss not ready ", lbl}, 32'(fetch_ready), 0);
            if (s < 0) begin
                s = m_order[3];
                m_valid[s] = 1'b1;
                m_tag[s]   = a[31:5];
                m_pres[s]  = '0;
                @(negedge clk); #0.5;
                chk(mem_req === 1'b0, {"R4 R5 retarget cycle ", lbl}, 32'(mem_req), 0);
            end
            @(negedge clk); #0.5;
            chk(mem_req === 1'b1, {"R3 R4 R5 request raised ", lbl}, 32'(mem_req), 1);
            chk(mem_addr === a, {"R3 request address ", lbl}, mem_addr, a);
            d = $urandom_range(0, 3);
            repeat (d) begin
                @(negedge clk); #0.5;
                chk(mem_req === 1'b1 && mem_addr === a, {"R8 request held ", lbl}, mem_addr, a);
                chk(fetch_ready === 1'b0, {"R8 not ready while waiting ", lbl}, 32'(fetch_ready), 0);
            end
            mem_ack  = 1'b1;
            mem_data = ext_word(a);
            #0.5;
            chk(fetch_ready === 1'b1, {"R3 fill ready ", lbl}, 32'(fetch_ready), 1);
            chk(fetch_data === ext_word(a), {"R1 R3 fill data ", lbl}, fetch_data, ext_word(a));
            m_pres[s][o] = 1'b1;
            touch(s);
            @(negedge clk);
            mem_ack  = 1'b0;
            mem_data = '0;
        end
        fetch_req = 1'b0;
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 4; i++) begin
            m_pres[i]  = '0;
            m_order[i] = i;
        end
    endtask

    function automatic logic [31:0] mk(input logic [26:0] t, input int o);
        return {t, 5'(o)};
    endfunction

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [26:0] pool [6];
        void'($urandom(32'd20240611));
        for (int i = 0; i < 6; i++) pool[i] = 27'h0ABC00 + 27'(i * 27'h111);
        for (int i = 0; i < 4; i++) begin
            m_valid[i] = 1'b0; m_tag[i] = '0; m_pres[i] = '0; m_order[i] = i;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #0.5;
        chk(fetch_ready === 1'b0, "R9 reset ready low", 32'(fetch_ready), 0);
        chk(mem_req === 1'b0, "R9 reset request low", 32'(mem_req), 0);

        // R9: every first fetch is a tag miss; fills segments 3,2,1,0
        for (int i = 0; i < 4; i++) do_fetch(mk(pool[i], 0), "R9 cold");
        do_fetch(mk(pool[0], 0), "R2 repeat");
        do_fetch(mk(pool[0], 31), "R3 offset 31");
        do_fetch(mk(pool[0], 31), "R3 refetch");
        // R5: refresh pool 0, then a new tag must take the LRU segment
        for (int i = 1; i < 4; i++) do_fetch(mk(pool[i], 0), "R5 touch");
        do_fetch(mk(pool[0], 0), "R5 touch");
        do_fetch(mk(pool[4], 5), "R5 new tag");
        do_fetch(mk(pool[1], 0), "R5 evicted tag");
        // R4: reused segment must not keep the old offset-0 flag
        do_fetch(mk(pool[4], 0), "R4 stale flag");
        // R6 then R7
        do_flush();
        do_fetch(mk(pool[4], 5), "R6 flushed word");
        do_flush();
        do_fetch(mk(pool[5], 1), "R7 first miss after flush");
        for (int i = 0; i < 5; i++) do_fetch(mk(pool[i], 1), "R7 follow up");

        // constrained random mix
        for (int n = 0; n < 400; n++) begin
            int k = $urandom_range(0, 5);
            int r = $urandom_range(0, 2);
            int o = (r == 0) ? 0 : (r == 1) ? 31 : $urandom_range(0, 31);
            if ($urandom_range(0, 39) == 0) do_flush();
            do_fetch(mk(pool[k], o), "random R1 R5");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule